// File: doc/BRIEF.md
# Sub-Pixel Hit and Timing Cell

This block is the digital part of one detector cell whose charge is collected by eight sub-pixel diodes, each with its own discriminator. While an acquisition window is open, the cell keeps one hit bit per discriminator. It also watches the logical OR of all eight discriminators and makes two measurements at the same time. The first is the arrival time, sampled from a shared time reference bus. The second is the time over threshold, counted in clock cycles. Counting runs only when the clock-enable input is high, so the periphery can gate the cell off outside the active period.

When the window closes, the cell offers its record on a valid/ready readout port, but only if at least one hit bit is set. A cell with no hits never raises valid, so downstream logic can skip it and zero suppression comes for free. There are three back-pressure rules:
- While valid is high and ready is low, the mask, arrival time and duration do not change, as long as the window stays closed.
- The cycle in which valid and ready are both high is the transfer.
- That transfer clears the cell for the next window.

The window must not be reopened while a record is still unread.

Top module: `hitcell_timing`

## Requirements
- R1: After reset, rd_valid is 0 and rd_mask, rd_toa and rd_tot are all 0.
- R2: A discriminator input disc_in[i] that is high at a clock edge k, while the window is open and clock-enable is high at edge k+2, sets rd_mask[i]. Bit i of the mask belongs to input i. Bits only accumulate within a window.
- R3: Let k be the first clock edge, since the last clear, at which the OR of disc_in is sampled high after being low. rd_toa takes the value time_ref has at edge k+2. Later rising edges do not change rd_toa.
- R4: rd_tot counts the clock edges at which the synchronized OR is high during the first pulse only, so a pulse held high for H cycles gives H. Later pulses in the same record add nothing.
- R5: rd_tot saturates at 31 and never wraps.
- R6: At a clock edge where shutter is low, nothing in the record changes except through a transfer. A pulse still high when the window closes keeps the count it had reached. Discriminator activity while the window is closed is ignored.
- R7: At a clock edge where clk_en is low, the mask, rd_toa and rd_tot do not change.
- R8: rd_valid is high exactly when shutter is low and the mask is non-zero. While rd_valid is high and rd_ready is low, the record is held stable.
- R9: A transfer (rd_valid and rd_ready high at an edge) returns the mask, rd_toa and rd_tot to 0 and re-arms arrival capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Gating enable; low freezes all measurement state |
| shutter | input | 1 | Acquisition window, high = open |
| disc_in | input | 8 | Discriminator outputs, one per sub-pixel diode |
| time_ref | input | 8 | Shared time reference bus |
| rd_valid | output | 1 | Record available (window closed, some hit) |
| rd_ready | input | 1 | Consumer accepts the record; the transfer clears the cell |
| rd_mask | output | 8 | Per-diode hit mask |
| rd_toa | output | 8 | Captured arrival time |
| rd_tot | output | 5 | Time over threshold, saturating |

## Verification
Two cases are the hardest to reach from the ports.

The first is closing the window while a pulse is still above threshold. Only that case shows that the duration freezes, rather than continuing or resuming. The stimulus holds one discriminator high, drops shutter a known number of cycles after the rise, and keeps the input high past the close.

The second is exact arrival timing through the two-stage synchronizer. The bench changes time_ref on each of the cycles right after the rise, so only a capture at the correct edge yields the expected value. A second pulse is then sent, with a new reference value, to show that later edges are ignored.

// File: rtl/htc_pkg.sv
package htc_pkg;
  localparam int unsigned DEF_N_IN  = 8;
  localparam int unsigned DEF_TOA_W = 8;
  localparam int unsigned DEF_TOT_W = 5;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/htc_sync.sv
module htc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/htc_toa.sv
module htc_toa #(
  parameter int TOA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             rise,
  input  logic             clr,
  input  logic [TOA_W-1:0] time_ref,
  output logic [TOA_W-1:0] toa,
  output logic             seen
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      toa  <= '0;
      seen <= 1'b0;
    end else if (act && rise && !seen) begin
      toa  <= time_ref;
      seen <= 1'b1;
    end
  end
endmodule

// File: rtl/htc_tot.sv
module htc_tot #(
  parameter int TOT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             win,
  input  logic             level,
  input  logic             start,
  input  logic             clr,
  output logic [TOT_W-1:0] tot
);
  localparam logic [TOT_W-1:0] TOT_MAX = '1;

  logic run;
  logic cnt_en;

  assign cnt_en = clk_en && win && level && (start || run);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      run <= 1'b0;
    end else if (clk_en) begin
      if (!win || !level) run <= 1'b0;
      else if (start)     run <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tot <= '0;
    end else if (cnt_en && tot != TOT_MAX) begin
      tot <= tot + 1'b1;
    end
  end
endmodule

// File: rtl/hitcell_timing.sv
module hitcell_timing
  import htc_pkg::*;
#(
  parameter int N_IN        = DEF_N_IN,
  parameter int TOA_W       = DEF_TOA_W,
  parameter int TOT_W       = DEF_TOT_W,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             shutter,
  input  logic [N_IN-1:0]  disc_in,
  input  logic [TOA_W-1:0] time_ref,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [N_IN-1:0]  rd_mask,
  output logic [TOA_W-1:0] rd_toa,
  output logic [TOT_W-1:0] rd_tot
);
  logic [N_IN-1:0] disc_s;
  logic            or_now;
  logic            or_prev;
  logic            rise;
  logic            act;
  logic            xfer;
  logic            seen;
  logic [N_IN-1:0] mask_q;

  htc_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(disc_in), .q(disc_s)
  );

  assign or_now = |disc_s;
  assign rise   = or_now && !or_prev;
  assign act    = clk_en && shutter;
  assign xfer   = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) or_prev <= 1'b0;
    else        or_prev <= or_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || xfer) mask_q <= '0;
    else if (act)       mask_q <= mask_q | disc_s;
  end

  htc_toa #(.TOA_W(TOA_W)) u_toa (
    .clk(clk), .rst_n(rst_n), .act(act), .rise(rise), .clr(xfer),
    .time_ref(time_ref), .toa(rd_toa), .seen(seen)
  );

  htc_tot #(.TOT_W(TOT_W)) u_tot (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .win(shutter),
    .level(or_now), .start(rise && !seen), .clr(xfer), .tot(rd_tot)
  );

  assign rd_mask  = mask_q;
  assign rd_valid = !shutter && (mask_q != '0);
endmodule

// File: rtl/htc_chk.sv
module htc_chk #(
  parameter int N_IN  = 8,
  parameter int TOA_W = 8,
  parameter int TOT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             shutter,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [N_IN-1:0]  rd_mask,
  input logic [TOA_W-1:0] rd_toa,
  input logic [TOT_W-1:0] rd_tot
);
  localparam logic [TOT_W-1:0] TOT_MAX = '1;
  logic xfer;
  assign xfer = rd_valid && rd_ready;

  a_r2_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> (($past(rd_mask) & ~rd_mask) == '0));

  a_r3_toa_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tot != '0 && !xfer) |=> $stable(rd_toa));

  a_r4_tot_step: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> (rd_tot == $past(rd_tot) || rd_tot == $past(rd_tot) + 1'b1));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tot == TOT_MAX && !xfer) |=> rd_tot == TOT_MAX);

  a_r6_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutter && !xfer) |=> ($stable(rd_mask) && $stable(rd_toa) && $stable(rd_tot)));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !xfer) |=> ($stable(rd_mask) && $stable(rd_toa) && $stable(rd_tot)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (shutter || ($stable(rd_mask) && $stable(rd_toa) && $stable(rd_tot))));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (rd_mask == '0 && rd_toa == '0 && rd_tot == '0 && !rd_valid));
endmodule

bind hitcell_timing htc_chk #(.N_IN(N_IN), .TOA_W(TOA_W), .TOT_W(TOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .shutter(shutter),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_mask(rd_mask),
  .rd_toa(rd_toa), .rd_tot(rd_tot)
);

// File: tb/hitcell_timing_bench.sv
module hitcell_timing_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic       shutter = 1'b0;
  logic [7:0] disc_in = '0;
  logic [7:0] time_ref = '0;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_mask;
  logic [7:0] rd_toa;
  logic [4:0] rd_tot;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hitcell_timing u_hitcell_timing (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .shutter(shutter),
    .disc_in(disc_in), .time_ref(time_ref), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_mask(rd_mask), .rd_toa(rd_toa), .rd_tot(rd_tot)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic open_win();
    @(negedge clk); shutter = 1'b1;
  endtask

  task automatic close_win();
    idle(4);
    shutter = 1'b0;
    #1;
  endtask

  task automatic pulse(logic [7:0] m, int h);
    @(negedge clk); disc_in = m;
    idle(h);
    disc_in = '0;
  endtask

  task automatic accept();
    @(negedge clk); rd_ready = 1'b1;
    @(posedge clk); #1;
    check("R9", "mask after transfer", rd_mask, 0);
    check("R9", "toa after transfer", rd_toa, 0);
    check("R9", "tot after transfer", rd_tot, 0);
    check("R9", "valid after transfer", rd_valid, 0);
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    #1;
    check("R1", "valid", rd_valid, 0);
    check("R1", "mask", rd_mask, 0);
    check("R1", "toa", rd_toa, 0);
    check("R1", "tot", rd_tot, 0);
  endtask

  task automatic t_single();
    open_win();
    @(negedge clk); disc_in = 8'h08; time_ref = 8'd10;
    @(negedge clk); time_ref = 8'd20;
    @(negedge clk); time_ref = 8'd30;
    idle(4);
    disc_in = '0;
    close_win();
    check("R8", "valid with hits", rd_valid, 1);
    check("R2", "single mask", rd_mask, 8'h08);
    check("R3", "toa at edge k+2", rd_toa, 30);
    check("R4", "tot six cycles", rd_tot, 6);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check("R8", "held mask", rd_mask, 8'h08);
      check("R8", "held toa", rd_toa, 30);
    end
    accept();
  endtask

  task automatic t_multi();
    @(negedge clk); time_ref = 8'd77;
    open_win();
    pulse(8'h81, 3);
    idle(3);
    time_ref = 8'd99;
    pulse(8'h24, 10);
    close_win();
    check("R2", "accumulated mask", rd_mask, 8'hA5);
    check("R3", "later edge ignored", rd_toa, 77);
    check("R4", "first pulse only", rd_tot, 3);
    accept();
  endtask

  task automatic t_sat(int h, int exp);
    open_win();
    pulse(8'h02, h);
    close_win();
    check("R5", "saturating tot", rd_tot, exp);
    accept();
  endtask

  task automatic t_close();
    @(negedge clk); time_ref = 8'd5;
    open_win();
    @(negedge clk); disc_in = 8'h40;
    idle(5);
    shutter = 1'b0;
    idle(6);
    #1;
    check("R6", "tot frozen at close", rd_tot, 3);
    disc_in = 8'h01;
    idle(5);
    disc_in = '0;
    idle(3);
    #1;
    check("R6", "closed-window hit ignored", rd_mask, 8'h40);
    check("R6", "tot unchanged after close", rd_tot, 3);
    accept();
    pulse(8'h10, 4);
    idle(3);
    #1;
    check("R6", "no record outside window", rd_valid, 0);
    check("R6", "mask outside window", rd_mask, 0);
  endtask

  task automatic t_gate();
    @(negedge clk); clk_en = 1'b0;
    open_win();
    pulse(8'h10, 5);
    idle(3);
    clk_en = 1'b1;
    close_win();
    check("R7", "gated mask", rd_mask, 0);
    check("R7", "gated tot", rd_tot, 0);
    check("R7", "gated valid", rd_valid, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_sat(31, 31);
    t_sat(40, 31);
    t_close();
    t_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule